// File: doc/BRIEF.md
# Horizontal Pairwise Add/Subtract Unit

This unit reduces neighbouring element pairs inside a packed vector. It takes two 128-bit sources. Each adjacent pair of elements in a source is combined into one element by an add or a subtract. The pair results of the first source fill the low half of the destination, and those of the second source fill the high half. Elements are either 16 or 32 bits wide. For 16-bit elements a signed saturating mode is also available: results that leave the signed range are pinned to its limits.

A caller presents both operands together with the operation, size and saturation selects, and pulses the input strobe. The packed result appears on the output register one clock later, marked by the output strobe. Between operations the output register keeps its last value.

Top module: `hpair_unit`

## Requirements
- R1: A synchronous active-high reset (`rst`) clears `result` to zero and drops `out_valid` on the next clock edge.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, which gives one cycle of latency. The result of that input is on `result` in the same cycle.
- R3: With `size_32`=0 and `op_sub`=0, output element k (16 bits at bit 16k) for k in 0..3 is source-a element 2k plus element 2k+1. For k in 4..7 it is the same sum taken from source b, elements 2(k-4) and 2(k-4)+1. Element i of a source sits at bits [16i+15:16i]. With `sat_en`=0 the sum wraps modulo 2^16.
- R4: With `op_sub`=1 each pair yields the even-indexed element minus the odd-indexed element, under the same packing. With `sat_en`=0 the difference wraps modulo 2^16 or 2^32.
- R5: With `size_32`=0, `op_sub`=0 and `sat_en`=1, a sum above 32767 gives 0x7FFF and a sum below -32768 gives 0x8000.
- R6: With `size_32`=0, `op_sub`=1 and `sat_en`=1, a difference above 32767 gives 0x7FFF and one below -32768 gives 0x8000.
- R7: With `size_32`=1, output element k (32 bits at bit 32k) for k in 0..1 comes from source-a elements 2k and 2k+1, and for k in 2..3 from source b. Results wrap modulo 2^32.
- R8: With `size_32`=1, `sat_en` has no effect on the result.
- R9: While `in_valid` is low, `result` holds its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and selects are valid this cycle |
| op_sub | input | 1 | 0: add pairs, 1: even minus odd |
| size_32 | input | 1 | 0: 16-bit elements, 1: 32-bit elements |
| sat_en | input | 1 | Signed saturation for 16-bit elements |
| src_a | input | 128 | First source, feeds the low half of the result |
| src_b | input | 128 | Second source, feeds the high half of the result |
| result | output | 128 | Registered packed result |
| out_valid | output | 1 | Result registered from the previous cycle's input |

## Verification
The assertions assume that the operands and selects are meaningful only in cycles with `in_valid` high. They relate an overflow seen in a 16-bit pair lane during such a cycle to a clamped value on the next cycle's output. They also assume that reset is held for at least one full clock before any operation. The stimulus asserts reset for several cycles first, changes operands and selects freely while `in_valid` is low to exercise the hold behaviour, and covers every combination of size, operation and saturation with directed limit values and pseudo-random operands.

// File: rtl/hpair_pkg.sv
package hpair_pkg;

  // Operation encoding on the op_sub input
  typedef enum logic {
    PAIR_ADD = 1'b0,
    PAIR_SUB = 1'b1
  } pair_op_e;

  // Widest element handled by the shared arithmetic, plus one guard bit
  localparam int ARITH_W = 32;
  localparam int WIDE_W  = ARITH_W + 1;

  // Combine two sign-extended elements; sub picks even minus odd
  function automatic logic signed [WIDE_W-1:0] pair_combine(
    input logic signed [ARITH_W-1:0] even_el,
    input logic signed [ARITH_W-1:0] odd_el,
    input logic                      sub
  );
    logic signed [WIDE_W-1:0] ev;
    logic signed [WIDE_W-1:0] od;
    ev = WIDE_W'(even_el);
    od = WIDE_W'(odd_el);
    return sub ? (ev - od) : (ev + od);
  endfunction

endpackage

// File: rtl/hpair_pair.sv
module hpair_pair #(
  parameter int EW     = 16,
  parameter bit SAT_OK = 1'b1
) (
  input  logic [EW-1:0] even_el,
  input  logic [EW-1:0] odd_el,
  input  logic          sub,
  input  logic          sat,
  output logic [EW-1:0] res,
  output logic          ovf
);
  import hpair_pkg::*;

  localparam logic [EW-1:0] POS_LIMIT = {1'b0, {(EW-1){1'b1}}};
  localparam logic [EW-1:0] NEG_LIMIT = {1'b1, {(EW-1){1'b0}}};

  logic signed [ARITH_W-1:0] ev_ext;
  logic signed [ARITH_W-1:0] od_ext;
  logic signed [WIDE_W-1:0]  wide;
  logic [EW-1:0]             wrapped;
  logic                      true_sign;
  logic                      unused_wide;

  assign ev_ext    = ARITH_W'(signed'(even_el));
  assign od_ext    = ARITH_W'(signed'(odd_el));
  assign wide      = pair_combine(ev_ext, od_ext, sub);
  assign wrapped   = wide[EW-1:0];
  assign true_sign = wide[EW];
  assign ovf       = wide[EW] ^ wide[EW-1];
  assign unused_wide = ^wide;

  generate
    if (SAT_OK) begin : g_sat
      assign res = (sat && ovf) ? (true_sign ? NEG_LIMIT : POS_LIMIT) : wrapped;
    end else begin : g_wrap
      logic unused_sat;
      assign unused_sat = sat;
      assign res = wrapped;
    end
  endgenerate

endmodule

// File: rtl/hpair_outreg.sv
module hpair_outreg #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         q_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q       <= '0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= load;
      if (load) begin
        q <= d;
      end
    end
  end

endmodule

// File: rtl/hpair_unit.sv
module hpair_unit #(
  parameter int DATA_W      = 128,
  parameter int LANE_NARROW = 16,
  parameter int LANE_WIDE   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              op_sub,
  input  logic              size_32,
  input  logic              sat_en,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [DATA_W-1:0] result,
  output logic              out_valid
);

  localparam int N_NARROW = DATA_W / LANE_NARROW;
  localparam int N_WIDE   = DATA_W / LANE_WIDE;
  localparam int CAT_W    = 2 * DATA_W;

  // Sources side by side: a occupies the low elements, b the high ones,
  // so pair k of the joined vector lands in output element k.
  logic [CAT_W-1:0]    joined;
  logic [DATA_W-1:0]   narrow_res;
  logic [DATA_W-1:0]   wide_res;
  logic [N_NARROW-1:0] narrow_ovf;
  logic [N_WIDE-1:0]   wide_ovf_unused;
  logic [DATA_W-1:0]   next_res;

  assign joined = {src_b, src_a};

  genvar k;
  generate
    for (k = 0; k < N_NARROW; k++) begin : g_narrow
      hpair_pair #(.EW(LANE_NARROW), .SAT_OK(1'b1)) u_pair (
        .even_el (joined[(2*k)*LANE_NARROW +: LANE_NARROW]),
        .odd_el  (joined[(2*k+1)*LANE_NARROW +: LANE_NARROW]),
        .sub     (op_sub),
        .sat     (sat_en),
        .res     (narrow_res[k*LANE_NARROW +: LANE_NARROW]),
        .ovf     (narrow_ovf[k])
      );
    end
    for (k = 0; k < N_WIDE; k++) begin : g_wide
      hpair_pair #(.EW(LANE_WIDE), .SAT_OK(1'b0)) u_pair (
        .even_el (joined[(2*k)*LANE_WIDE +: LANE_WIDE]),
        .odd_el  (joined[(2*k+1)*LANE_WIDE +: LANE_WIDE]),
        .sub     (op_sub),
        .sat     (1'b0),
        .res     (wide_res[k*LANE_WIDE +: LANE_WIDE]),
        .ovf     (wide_ovf_unused[k])
      );
    end
  endgenerate

  assign next_res = size_32 ? wide_res : narrow_res;

  hpair_outreg #(.W(DATA_W)) u_outreg (
    .clk     (clk),
    .rst     (rst),
    .load    (in_valid),
    .d       (next_res),
    .q       (result),
    .q_valid (out_valid)
  );

endmodule

// File: rtl/hpair_chk.sv
module hpair_chk #(
  parameter int DATA_W      = 128,
  parameter int LANE_NARROW = 16
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            in_valid,
  input logic                            op_sub,
  input logic                            size_32,
  input logic                            sat_en,
  input logic [DATA_W/LANE_NARROW-1:0]   narrow_ovf,
  input logic [DATA_W-1:0]               result,
  input logic                            out_valid
);
  localparam int N_NARROW = DATA_W / LANE_NARROW;
  localparam logic [LANE_NARROW-1:0] POS_LIMIT = {1'b0, {(LANE_NARROW-1){1'b1}}};
  localparam logic [LANE_NARROW-1:0] NEG_LIMIT = {1'b1, {(LANE_NARROW-1){1'b0}}};

  logic unused_op;
  assign unused_op = op_sub;

  // R1: reset clears the output register and strobe
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (result == '0 && !out_valid));

  // R2: strobe follows the input strobe by one cycle
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R9: no input strobe, no change on the result
  p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  // R5 / R6: an overflowing 16-bit lane in saturating mode lands on a limit
  genvar k;
  generate
    for (k = 0; k < N_NARROW; k++) begin : g_clamp
      p_clamp_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !size_32 && sat_en && narrow_ovf[k]) |=>
          (result[k*LANE_NARROW +: LANE_NARROW] == POS_LIMIT ||
           result[k*LANE_NARROW +: LANE_NARROW] == NEG_LIMIT));
    end
  endgenerate

endmodule

bind hpair_unit hpair_chk #(
  .DATA_W      (DATA_W),
  .LANE_NARROW (LANE_NARROW)
) u_hpair_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .op_sub     (op_sub),
  .size_32    (size_32),
  .sat_en     (sat_en),
  .narrow_ovf (narrow_ovf),
  .result     (result),
  .out_valid  (out_valid)
);

// File: tb/test_hpair_unit.sv
module test_hpair_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         op_sub = 1'b0;
  logic         size_32 = 1'b0;
  logic         sat_en = 1'b0;
  logic [127:0] src_a = '0;
  logic [127:0] src_b = '0;
  logic [127:0] result;
  logic         out_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string cur_tag = "R1";

  // reference model state
  logic [127:0] exp_res = '0;
  logic         exp_vld = 1'b0;
  string        exp_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  hpair_unit i_hpair_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
    .size_32(size_32), .sat_en(sat_en), .src_a(src_a), .src_b(src_b),
    .result(result), .out_valid(out_valid)
  );

  function automatic longint elem(input logic [127:0] v, input int idx, input bit w32);
    if (w32) return longint'($signed(v[idx*32 +: 32]));
    return longint'($signed(v[idx*16 +: 16]));
  endfunction

  function automatic logic [127:0] ref_calc(input logic [127:0] a, input logic [127:0] b,
                                            input bit sub, input bit w32, input bit sat);
    logic [127:0] r;
    int n;
    r = '0;
    n = w32 ? 4 : 8;
    for (int k = 0; k < n; k++) begin
      longint x, y, s;
      int j;
      j = (k < n/2) ? k : k - n/2;
      x = elem((k < n/2) ? a : b, 2*j, w32);
      y = elem((k < n/2) ? a : b, 2*j+1, w32);
      s = sub ? x - y : x + y;
      if (w32) begin
        r[k*32 +: 32] = s[31:0];
      end else begin
        if (sat && s > 32767)  s = 32767;
        if (sat && s < -32768) s = -32768;
        r[k*16 +: 16] = s[15:0];
      end
    end
    return r;
  endfunction

  function automatic logic [127:0] v16(input int e0, e1, e2, e3, e4, e5, e6, e7);
    return {e7[15:0], e6[15:0], e5[15:0], e4[15:0], e3[15:0], e2[15:0], e1[15:0], e0[15:0]};
  endfunction

  function automatic logic [127:0] v32(input int e0, e1, e2, e3);
    return {e3, e2, e1, e0};
  endfunction

  // behavioural model, updated on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      exp_res <= '0;
      exp_vld <= 1'b0;
      exp_tag <= "R1";
    end else begin
      exp_vld <= in_valid;
      exp_tag <= in_valid ? cur_tag : "R9";
      if (in_valid) exp_res <= ref_calc(src_a, src_b, op_sub, size_32, sat_en);
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (result !== exp_res || out_valid !== exp_vld) begin
        fails++;
        $display("FAIL %s: actual result=%h valid=%b expected result=%h valid=%b (R2 timing)",
                 exp_tag, result, out_valid, exp_res, exp_vld);
      end
    end
  end

  task automatic drive(input string tag, input bit v, input bit sub, input bit w32,
                       input bit sat, input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    #1;
    cur_tag  = tag;
    in_valid = v;
    op_sub   = sub;
    size_32  = w32;
    sat_en   = sat;
    src_a    = a;
    src_b    = b;
  endtask

  task automatic check_const(input string tag, input logic [127:0] expv);
    @(negedge clk);
    #2;
    checks++;
    if (result !== expv) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, result, expv);
    end
  endtask

  initial begin
    logic [127:0] base_a;
    base_a = v16(1, 2, 3, 4, 5, 6, 7, 8);
    repeat (4) @(negedge clk);
    // R1: reset state
    checks++;
    if (result !== '0 || out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: actual=%h/%b expected=0/0", result, out_valid);
    end
    @(negedge clk); #1; rst = 1'b0;

    // R3: 16-bit add
    drive("R3", 1, 0, 0, 0, base_a, v16(4, 128, 4, 3, 24, 12, 6, 19));
    drive("R9", 0, 1, 1, 1, '1, '1);
    check_const("R3", v16(3, 7, 11, 15, 132, 7, 36, 25));
    // R4: 16-bit subtract, even minus odd
    drive("R4", 1, 1, 0, 0, base_a, v16(4, 128, 4, 3, 24, 12, 6, 19));
    drive("R9", 0, 0, 0, 0, '0, '0);
    check_const("R4", v16(-1, -1, -1, -1, -124, 1, 12, -13));
    // R3 wrap without saturation
    drive("R3", 1, 0, 0, 0, v16(32767, 1, -32768, -1, 0, 0, 0, 0), v16(32767, 32767, 0, 0, 0, 0, 0, 0));
    // R5: saturating add
    drive("R5", 1, 0, 0, 1, base_a, v16(4, 128, 4, 3, 32767, 1, -32768, -1));
    drive("R9", 0, 0, 0, 1, '0, '0);
    check_const("R5", v16(3, 7, 11, 15, 132, 7, 32767, -32768));
    // R6: saturating subtract
    drive("R6", 1, 1, 0, 1, base_a, v16(4, 128, 4, 3, 32767, -1, -32768, 1));
    drive("R9", 0, 0, 0, 0, '0, '0);
    check_const("R6", v16(-1, -1, -1, -1, -124, 1, 32767, -32768));
    // R7: 32-bit add and subtract
    drive("R7", 1, 0, 1, 0, v32(1, 2, 3, 4), v32(4, 128, 4, 3));
    drive("R9", 0, 0, 0, 0, '0, '0);
    check_const("R7", v32(3, 7, 132, 7));
    drive("R7", 1, 1, 1, 0, v32(1, 2, 3, 4), v32(4, 128, 4, 3));
    drive("R9", 0, 0, 0, 0, '0, '0);
    check_const("R7", v32(-1, -1, -124, 1));
    // R8: saturation request ignored on 32-bit lanes (wraps)
    drive("R8", 1, 0, 1, 1, v32(32'h7fffffff, 1, 32'h80000000, -1), v32(32767, 1, 0, 0));
    drive("R9", 0, 0, 0, 0, '0, '0);
    check_const("R8", v32(32'h80000000, 32'h7fffffff, 32768, 0));
    // R9: long idle stretch with toggling inputs
    for (int i = 0; i < 20; i++)
      drive("R9", 0, i[0], i[1], i[2], {4{$urandom}}, {4{$urandom}});
    // mixed random traffic, back-to-back and gapped
    for (int i = 0; i < 600; i++) begin
      bit sub, w32, sat, v;
      string tg;
      sub = $urandom_range(0, 1) == 1;
      w32 = $urandom_range(0, 1) == 1;
      sat = $urandom_range(0, 1) == 1;
      v   = $urandom_range(0, 3) != 0;
      if (w32) tg = sat ? "R8" : "R7";
      else if (sat) tg = sub ? "R6" : "R5";
      else tg = sub ? "R4" : "R3";
      drive(tg, v, sub, w32, sat,
            {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom});
    end
    drive("R2", 0, 0, 0, 0, '0, '0);
    repeat (3) @(negedge clk);
    // R1: reset in mid-run clears everything
    #1; rst = 1'b1;
    @(negedge clk); @(negedge clk);
    #2;
    done = 1'b1;
    checks++;
    if (result !== '0 || out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: actual=%h/%b expected=0/0", result, out_valid);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    done = 1'b1;
    fails++;
    $display("FAIL R2: watchdog expired, actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule